// File: doc/BRIEF.md
# Fast Call and Return Sequencer

This block carries out a lightweight subroutine call or return for a processor pipeline. A call saves only the return-address register, not a full register context. The block pushes that register onto a stack in memory that grows toward lower addresses, loads the link with the next instruction address and works out the branch target. A return does the opposite. It branches to the saved link, pops the old link from the stack and moves the stack pointer back up.

The pipeline presents one command together with the current PC, the next PC, a 24-bit displacement, an address-register value, the stack pointer and the return-address register. The block then makes a single 32-bit memory access over a valid/ready handshake. It commits the new PC, stack pointer and return-address register only once that access has finished, and it signals the commit with a one-cycle done pulse. The committed values stay on the outputs until the next commit.

Top module: `fcall_seq`

## Requirements
- R1: After reset, cmd_ready_o is 1 and mem_valid_o, done_o, pc_o, sp_o and ra_o are all 0.
- R2: A call (cmd_i 0, 1 or 2) issues a write (mem_we_o=1) of ra_i to address sp_i-4, and it commits sp_o = sp_i-4.
- R3: A call commits ra_o = next_pc_i.
- R4: A relative call (cmd_i=0) commits pc_o = pc_i + 2*sign_extend(disp_i).
- R5: An absolute call (cmd_i=1) commits pc_o with disp_i[23:20] in bits 31:28, disp_i[19:0] in bits 20:1, and every other bit 0.
- R6: An indirect call (cmd_i=2) commits pc_o = areg_i with bit 0 cleared.
- R7: A return (cmd_i=3) issues a read (mem_we_o=0) at address sp_i. It commits pc_o = ra_i with bit 0 cleared, ra_o = the loaded word and sp_o = sp_i+4.
- R8: While the memory access waits, the request, its address and its write data stay stable, and done_o and the committed outputs do not change. done_o is high for exactly the one cycle after the cycle in which mem_valid_o and mem_ready_i are both high.
- R9: cmd_ready_o is 0 while a memory request is outstanding, and the command inputs are ignored while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block idle; command accepted when valid |
| cmd_i | input | 2 | 0 relative call, 1 absolute call, 2 indirect call, 3 return |
| pc_i | input | 32 | PC of the current instruction |
| next_pc_i | input | 32 | Address of the following instruction |
| disp_i | input | 24 | Call displacement or segmented target field |
| areg_i | input | 32 | Address register for an indirect call |
| sp_i | input | 32 | Current stack pointer |
| ra_i | input | 32 | Current return-address register |
| mem_valid_o | output | 1 | Memory request |
| mem_ready_i | input | 1 | Memory access completes this cycle |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Word address of the access |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with mem_ready_i |
| pc_o | output | 32 | Committed new PC |
| sp_o | output | 32 | Committed stack pointer |
| ra_o | output | 32 | Committed return-address register |
| done_o | output | 1 | One-cycle commit pulse |

## Verification
The hardest state to reach is a return whose memory access is held off for several cycles. During that wait, the link value for the new PC has already been captured, but the register it came from is about to be overwritten by the load. The bench sweeps every command across a range of displacement and register patterns and varies the memory wait from zero to three cycles. While the wait lasts, it changes the command inputs and raises cmd_valid_i, and it checks that no output moves until the handshake completes.

// File: rtl/fcall_pkg.sv
package fcall_pkg;
  typedef enum logic [1:0] {
    FC_REL = 2'd0,
    FC_ABS = 2'd1,
    FC_IND = 2'd2,
    FC_RET = 2'd3
  } fc_cmd_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_XFER = 1'b1
  } fc_state_e;
endpackage

// File: rtl/fcall_target.sv
module fcall_target
  import fcall_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 24,
  parameter int SEG_W  = 4
) (
  input  fc_cmd_e           cmd_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   areg_i,
  input  logic [XLEN-1:0]   ra_i,
  output logic [XLEN-1:0]   target_o
);
  localparam int OFF_W = DISP_W - SEG_W;
  localparam int GAP_W = XLEN - SEG_W - OFF_W - 1;

  logic [XLEN-1:0] rel_tgt, abs_tgt;
  logic [XLEN-1:0] disp_sx;

  assign disp_sx = {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign rel_tgt = pc_i + (disp_sx << 1);
  // segment nibble to the top, halfword offset at bit 1
  assign abs_tgt = {disp_i[DISP_W-1 -: SEG_W], {GAP_W{1'b0}}, disp_i[OFF_W-1:0], 1'b0};

  always_comb begin
    unique case (cmd_i)
      FC_REL:  target_o = rel_tgt;
      FC_ABS:  target_o = abs_tgt;
      FC_IND:  target_o = {areg_i[XLEN-1:1], 1'b0};
      default: target_o = {ra_i[XLEN-1:1], 1'b0};
    endcase
  end
endmodule

// File: rtl/fcall_ctrl.sv
module fcall_ctrl
  import fcall_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  input  fc_cmd_e         cmd_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] next_pc_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] ra_i,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] sp_o,
  output logic [XLEN-1:0] ra_o,
  output logic            done_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

  fc_state_e       state_q;
  logic            is_ret_q, done_q;
  logic [XLEN-1:0] tgt_q, sp_new_q, link_q, addr_q, wdata_q;
  logic [XLEN-1:0] pc_q, sp_q, ra_q;
  logic            accept, finish, is_ret;

  assign is_ret = (cmd_i == FC_RET);
  assign accept = cmd_valid_i && (state_q == S_IDLE);
  assign finish = (state_q == S_XFER) && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      is_ret_q <= 1'b0;
      tgt_q    <= '0;
      sp_new_q <= '0;
      link_q   <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      state_q  <= S_XFER;
      is_ret_q <= is_ret;
      // return target taken from the old link before the pop overwrites it
      tgt_q    <= target_i;
      link_q   <= next_pc_i;
      wdata_q  <= ra_i;
      addr_q   <= is_ret ? sp_i : sp_i - STEP;
      sp_new_q <= is_ret ? sp_i + STEP : sp_i - STEP;
    end else if (finish) begin
      state_q <= S_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      sp_q   <= '0;
      ra_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) begin
        pc_q <= tgt_q;
        sp_q <= sp_new_q;
        ra_q <= is_ret_q ? mem_rdata_i : link_q;
      end
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign mem_valid_o = (state_q == S_XFER);
  assign mem_we_o    = mem_valid_o && !is_ret_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign pc_o        = pc_q;
  assign sp_o        = sp_q;
  assign ra_o        = ra_q;
  assign done_o      = done_q;

  // R8
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_we_o));
  // R8
  done_after_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_valid_o && mem_ready_i));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  commit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && mem_ready_i) |=> $stable(pc_o) && $stable(sp_o) && $stable(ra_o));
  // R9
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && cmd_ready_o));
endmodule

// File: rtl/fcall_seq.sv
module fcall_seq
  import fcall_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int DISP_W     = 24,
  parameter int SEG_W      = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   next_pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   areg_i,
  input  logic [XLEN-1:0]   sp_i,
  input  logic [XLEN-1:0]   ra_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   sp_o,
  output logic [XLEN-1:0]   ra_o,
  output logic              done_o
);
  fc_cmd_e         cmd;
  logic [XLEN-1:0] target;

  assign cmd = fc_cmd_e'(cmd_i);

  fcall_target #(.XLEN(XLEN), .DISP_W(DISP_W), .SEG_W(SEG_W)) u_target (
    .cmd_i   (cmd),
    .pc_i    (pc_i),
    .disp_i  (disp_i),
    .areg_i  (areg_i),
    .ra_i    (ra_i),
    .target_o(target)
  );

  fcall_ctrl #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_ready_o(cmd_ready_o),
    .cmd_i      (cmd),
    .target_i   (target),
    .next_pc_i  (next_pc_i),
    .sp_i       (sp_i),
    .ra_i       (ra_i),
    .mem_valid_o(mem_valid_o),
    .mem_ready_i(mem_ready_i),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i),
    .pc_o       (pc_o),
    .sp_o       (sp_o),
    .ra_o       (ra_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/fcall_seq_test.sv
module fcall_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd = '0;
  logic [31:0] pc = '0, next_pc = '0, areg = '0, sp = '0, ra = '0;
  logic [23:0] disp = '0;
  logic        mem_valid, mem_ready = 1'b0, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [31:0] pc_out, sp_out, ra_out;
  logic        done;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  fcall_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_i(cmd),
    .pc_i(pc), .next_pc_i(next_pc), .disp_i(disp), .areg_i(areg),
    .sp_i(sp), .ra_i(ra),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc_out), .sp_o(sp_out), .ra_o(ra_out), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_target(input logic [1:0] c, input logic [31:0] p,
                                             input logic [23:0] d, input logic [31:0] a,
                                             input logic [31:0] r);
    logic [31:0] sx;
    sx = {{8{d[23]}}, d};
    case (c)
      2'd0: return p + sx * 2;
      2'd1: return ({8'h0, d & 24'hF00000} << 8) | ({8'h0, d & 24'h0FFFFF} << 1);
      2'd2: return a & ~32'h1;
      default: return r & ~32'h1;
    endcase
  endfunction

  task automatic run(input logic [1:0] c, input logic [23:0] d, input logic [31:0] seed, input int waits);
    logic [31:0] e_pc, e_sp, e_ra, e_addr, ld, old_pc, old_sp, old_ra;
    logic [31:0] s_pc, s_ra, s_sp;
    s_pc = 32'h8000_1000 ^ (seed << 4);
    s_sp = 32'h0000_4000 + (seed << 6);
    s_ra = 32'h9000_0003 ^ (seed << 8);
    ld   = 32'h5A00_0000 | seed;
    e_pc = exp_target(c, s_pc, d, seed * 32'h1357 + 32'h1, s_ra);
    e_addr = (c == 2'd3) ? s_sp : s_sp - 4;
    e_sp = (c == 2'd3) ? s_sp + 4 : s_sp - 4;
    e_ra = (c == 2'd3) ? ld : s_pc + 4;
    old_pc = pc_out; old_sp = sp_out; old_ra = ra_out;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 ready when idle", {31'b0, cmd_ready}, 32'h1);
    cmd = c; disp = d; pc = s_pc; next_pc = s_pc + 4; sp = s_sp; ra = s_ra;
    areg = seed * 32'h1357 + 32'h1;
    cmd_valid = 1'b1;
    @(negedge clk);
    // scramble inputs while busy: must be ignored (R9)
    cmd = ~c; disp = ~d; pc = ~s_pc; sp = ~s_sp; ra = ~s_ra; areg = ~areg; next_pc = 32'h0;
    chk(mem_valid == 1'b1, "R8 request raised", {31'b0, mem_valid}, 32'h1);
    chk(mem_addr == e_addr, (c == 2'd3) ? "R7 read address" : "R2 push address", mem_addr, e_addr);
    chk(mem_we == (c != 2'd3), (c == 2'd3) ? "R7 read strobe" : "R2 write strobe", {31'b0, mem_we}, {31'b0, c != 2'd3});
    if (c != 2'd3) chk(mem_wdata == s_ra, "R2 push data", mem_wdata, s_ra);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk(cmd_ready == 1'b0, "R9 busy", {31'b0, cmd_ready}, 32'h0);
      chk(done == 1'b0 && pc_out == old_pc && sp_out == old_sp && ra_out == old_ra,
          "R8 hold while waiting", pc_out, old_pc);
      chk(mem_addr == e_addr, "R8 address stable", mem_addr, e_addr);
    end
    mem_ready = 1'b1; mem_rdata = ld;
    @(negedge clk);
    mem_ready = 1'b0; mem_rdata = 32'hDEAD_BEEF; cmd_valid = 1'b0;
    chk(done == 1'b1, "R8 done pulse", {31'b0, done}, 32'h1);
    case (c)
      2'd0: chk(pc_out == e_pc, "R4 relative target", pc_out, e_pc);
      2'd1: chk(pc_out == e_pc, "R5 absolute target", pc_out, e_pc);
      2'd2: chk(pc_out == e_pc, "R6 indirect target", pc_out, e_pc);
      default: chk(pc_out == e_pc, "R7 return target", pc_out, e_pc);
    endcase
    chk(sp_out == e_sp, (c == 2'd3) ? "R7 pop sp" : "R2 push sp", sp_out, e_sp);
    chk(ra_out == e_ra, (c == 2'd3) ? "R7 reloaded link" : "R3 link", ra_out, e_ra);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", {31'b0, done}, 32'h0);
    chk(mem_valid == 1'b0, "R8 request dropped", {31'b0, mem_valid}, 32'h0);
  endtask

  initial begin
    logic [23:0] pats [8];
    pats[0] = 24'h000000; pats[1] = 24'h000001; pats[2] = 24'h7FFFFF; pats[3] = 24'h800000;
    pats[4] = 24'hFFFFFF; pats[5] = 24'hF00001; pats[6] = 24'h0FFFFF; pats[7] = 24'hA5C3E1;
    #3;
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 ready", {31'b0, cmd_ready}, 32'h1);
    chk(mem_valid == 1'b0 && done == 1'b0, "R1 idle", {30'b0, mem_valid, done}, 32'h0);
    chk(pc_out == 0 && sp_out == 0 && ra_out == 0, "R1 outputs", pc_out | sp_out | ra_out, 32'h0);
    #20 rst_n = 1'b1;
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 8; i++)
        run(c[1:0], pats[i], 32'(c * 8 + i), (c + i) % 4);
    // return right after a call, zero wait
    run(2'd0, 24'h000010, 32'h3, 0);
    run(2'd3, 24'h000000, 32'h3, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule